// File: doc/BRIEF.md
# Paged Memory Bank Mapper

This block sits between a 16-bit CPU and a 1 MB memory made of 64 pages of 16 KB each. It turns each CPU memory address into a 20-bit physical address. The two top CPU address bits choose one of four 16 KB windows. Each window has a page register, and that register supplies the six upper physical address bits. The lower half of the page space is ROM and the upper half is RAM, and the block drives a separate chip select for each device.

Software programs the mapping through byte-wide I/O writes. One port per window holds that window's page number, and one further port turns the mapping on or off. The page registers cannot be read back. After reset the mapping is off, so the four windows fall straight onto ROM pages 0 to 3. This makes execution begin in ROM page 0 without any set-up. The port decode does not look at I/O address bit 3, so each port answers at two addresses.

Top module: `page_mapper_top`

## Requirements
- R1: After reset the mapping is off. Every CPU address A then maps to physical address {4'b0000, A[15:0]}, which is window n landing on ROM page n.
- R2: An I/O write to 0x78, 0x79, 0x7A or 0x7B stores bits 5:0 of the data byte as the page of window 0, 1, 2 or 3. Data bits 7:6 are dropped.
- R3: An I/O write to 0x7C sets the mapping on when data bit 0 is 1 and off when it is 0. Data bits 7:1 are ignored.
- R4: I/O address bit 3 is not decoded. Writes to 0x70 to 0x73 act as writes to the four page ports, and a write to 0x74 acts as a write to the enable port.
- R5: I/O writes to any other address have no effect on the pages or on the enable. This covers 0x75 to 0x77, 0x7D to 0x7F, and every address whose bits 7:4 are not 4'h7.
- R6: While the mapping is on, the physical address is {page of window cpu_addr[15:14], cpu_addr[13:0]}.
- R7: The ROM select is high when a read or write strobe is active and physical address bit 19 is 0. The RAM select is high under the same strobe condition when bit 19 is 1. With no strobe active, neither select is high.
- R8: Several windows may hold the same page at once, and each of them then reaches that page.
- R9: Page writes made while the mapping is off are kept. They take effect once the mapping is switched on, and switching the mapping off does not clear them.
- R10: With the I/O write strobe low, no I/O address or data value changes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| io_addr | input | 8 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| cpu_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | CPU memory read strobe |
| mem_wr | input | 1 | CPU memory write strobe |
| phys_addr | output | 20 | Translated physical address; bits 18:0 go to the selected device |
| rom_cs | output | 1 | ROM device select |
| ram_cs | output | 1 | RAM device select |

## Verification
The assertions check several properties on every cycle:
- that at most one chip select is high, and that neither is high when no strobe is active;
- that each select agrees with physical address bit 19;
- that the offset bits pass through unchanged;
- that the bypass mapping holds whenever the mapping is off;
- that the enable flag follows a write to either enable alias and stays put when no write happens.

The bench scenarios cover what needs a history of writes. These include the per-window page contents and the dropping of data bits 7:6. They also include the aliasing of the page ports, the rejection of neighbouring addresses, and page values kept across a disable and enable. The case of one page shared by all four windows is also covered there.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;
  // One I/O bus transaction as seen by the port decoder
  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
    logic       wr;
  } io_req_t;

  // Number of low I/O address bits that select among the ports of the group
  localparam int unsigned IO_IDX_W = 3;
endpackage

// File: rtl/page_port_decode.sv
module page_port_decode
  import page_mapper_pkg::*;
#(
  parameter int unsigned NWIN      = 4,
  parameter logic [7:0]  IO_BASE   = 8'h78,
  parameter logic [7:0]  IO_IGNORE = 8'h08
) (
  input  io_req_t         io_req,
  output logic [NWIN-1:0] win_we,
  output logic            en_we
);
  localparam logic [7:0] IDX_MASK = 8'((1 << IO_IDX_W) - 1);
  localparam logic [7:0] CMP_MASK = ~(IDX_MASK | IO_IGNORE);

  logic                group_hit;
  logic [IO_IDX_W-1:0] idx;

  assign group_hit = io_req.wr && (((io_req.addr ^ IO_BASE) & CMP_MASK) == 8'h00);
  assign idx       = io_req.addr[IO_IDX_W-1:0];

  for (genvar i = 0; i < NWIN; i++) begin : g_win_dec
    assign win_we[i] = group_hit && (idx == IO_IDX_W'(i));
  end

  assign en_we = group_hit && (idx == IO_IDX_W'(NWIN));
endmodule

// File: rtl/page_reg_file.sv
module page_reg_file #(
  parameter int unsigned NWIN   = 4,
  parameter int unsigned PAGE_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NWIN-1:0]        win_we,
  input  logic                   en_we,
  input  logic [7:0]             wdata,
  output logic [NWIN*PAGE_W-1:0] pages,
  output logic                   map_en
);
  logic [PAGE_W-1:0] page_q [NWIN];
  logic [PAGE_W-1:0] page_d [NWIN];
  logic              en_q, en_d;

  for (genvar i = 0; i < NWIN; i++) begin : g_page
    always_comb begin
      page_d[i] = page_q[i];
      if (win_we[i]) page_d[i] = wdata[PAGE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) page_q[i] <= '0;
      else        page_q[i] <= page_d[i];
    end

    assign pages[i*PAGE_W +: PAGE_W] = page_q[i];
  end

  always_comb begin
    en_d = en_q;
    if (en_we) en_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign map_en = en_q;
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int unsigned NWIN   = 4,
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned OFS_W  = 14,
  parameter int unsigned WIN_W  = 2
) (
  input  logic [NWIN*PAGE_W-1:0]   pages,
  input  logic                     map_en,
  input  logic [WIN_W+OFS_W-1:0]   cpu_addr,
  input  logic                     mem_rd,
  input  logic                     mem_wr,
  output logic [PAGE_W+OFS_W-1:0]  phys_addr,
  output logic                     rom_cs,
  output logic                     ram_cs
);
  logic [WIN_W-1:0]  win;
  logic [PAGE_W-1:0] sel_page;
  logic              access;

  assign win = cpu_addr[WIN_W+OFS_W-1:OFS_W];

  always_comb begin
    if (map_en) sel_page = pages[win*PAGE_W +: PAGE_W];
    else        sel_page = PAGE_W'(win);
  end

  assign phys_addr = {sel_page, cpu_addr[OFS_W-1:0]};
  assign access    = mem_rd | mem_wr;
  assign rom_cs    = access & ~sel_page[PAGE_W-1];
  assign ram_cs    = access &  sel_page[PAGE_W-1];
endmodule

// File: rtl/page_mapper_top.sv
module page_mapper_top
  import page_mapper_pkg::*;
#(
  parameter int unsigned CPU_AW    = 16,
  parameter int unsigned OFS_W     = 14,
  parameter int unsigned PAGE_W    = 6,
  parameter logic [7:0]  IO_BASE   = 8'h78,
  parameter logic [7:0]  IO_IGNORE = 8'h08,
  localparam int unsigned WIN_W    = CPU_AW - OFS_W,
  localparam int unsigned NWIN     = 1 << WIN_W,
  localparam int unsigned PHYS_W   = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              rom_cs,
  output logic              ram_cs
);
  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  io_req_t                io_req;
  logic [NWIN-1:0]        win_we;
  logic                   en_we;
  logic [NWIN*PAGE_W-1:0] pages;
  logic                   map_en;

  assign io_req = '{addr: io_addr, data: io_wdata, wr: io_wr};

  page_port_decode #(
    .NWIN(NWIN), .IO_BASE(IO_BASE), .IO_IGNORE(IO_IGNORE)
  ) u_dec (
    .io_req(io_req), .win_we(win_we), .en_we(en_we)
  );

  page_reg_file #(
    .NWIN(NWIN), .PAGE_W(PAGE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n), .win_we(win_we), .en_we(en_we),
    .wdata(io_wdata), .pages(pages), .map_en(map_en)
  );

  page_xlate #(
    .NWIN(NWIN), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .WIN_W(WIN_W)
  ) u_xlate (
    .pages(pages), .map_en(map_en), .cpu_addr(cpu_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr),
    .phys_addr(phys_addr), .rom_cs(rom_cs), .ram_cs(ram_cs)
  );
endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk (
  input logic        clk,
  input logic        rst_core_n,
  input logic [7:0]  io_addr,
  input logic [7:0]  io_wdata,
  input logic        io_wr,
  input logic [15:0] cpu_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [19:0] phys_addr,
  input logic        rom_cs,
  input logic        ram_cs,
  input logic        map_en
);
  logic en_port_hit;
  assign en_port_hit = io_wr && (io_addr[7:4] == 4'h7) && (io_addr[2:0] == 3'd4);

  AST_RESET_OFF: assert property (@(posedge clk) $rose(rst_core_n) |-> !map_en); // R1
  AST_BYPASS_MAP: assert property (@(posedge clk) disable iff (!rst_core_n)
    !map_en |-> (phys_addr == {4'b0000, cpu_addr})); // R1
  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    en_port_hit |=> (map_en == $past(io_wdata[0]))); // R3
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !io_wr |=> $stable(map_en)); // R10
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_core_n)
    phys_addr[13:0] == cpu_addr[13:0]); // R6
  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0({rom_cs, ram_cs})); // R7
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(mem_rd || mem_wr) |-> (!rom_cs && !ram_cs)); // R7
  AST_CS_ROM_HALF: assert property (@(posedge clk) disable iff (!rst_core_n)
    rom_cs |-> !phys_addr[19]); // R7
  AST_CS_RAM_HALF: assert property (@(posedge clk) disable iff (!rst_core_n)
    ram_cs |-> phys_addr[19]); // R7
endmodule

bind page_mapper_top page_mapper_chk u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .phys_addr(phys_addr), .rom_cs(rom_cs), .ram_cs(ram_cs), .map_en(map_en)
);

// File: tb/tb_page_mapper_top.sv
module tb_page_mapper_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  io_addr, io_wdata;
  logic        io_wr;
  logic [15:0] cpu_addr;
  logic        mem_rd, mem_wr;
  logic [19:0] phys_addr;
  logic        rom_cs, ram_cs;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  page_mapper_top dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
    .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .phys_addr(phys_addr), .rom_cs(rom_cs), .ram_cs(ram_cs)
  );

  function automatic logic [19:0] mk_phys(input logic [5:0] page, input logic [15:0] a);
    return {page, a[13:0]};
  endfunction

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [15:0] a, input logic rd,
                       input logic wr, input logic [19:0] exp_pa,
                       input logic exp_rom, input logic exp_ram);
    @(negedge clk);
    cpu_addr = a; mem_rd = rd; mem_wr = wr;
    #1;
    checks++;
    if (phys_addr !== exp_pa || rom_cs !== exp_rom || ram_cs !== exp_ram) begin
      fails++;
      $display("FAIL %s: addr=%h got pa=%h rom=%b ram=%b exp pa=%h rom=%b ram=%b",
               tag, a, phys_addr, rom_cs, ram_cs, exp_pa, exp_rom, exp_ram);
    end
  endtask

  task automatic t_reset;
    probe("R1", 16'h0000, 1, 0, 20'h00000, 1, 0);
    probe("R1", 16'hC123, 1, 0, 20'h0C123, 1, 0);
    probe("R1", 16'h7FFF, 0, 1, 20'h07FFF, 1, 0);
  endtask

  task automatic t_map_windows;
    io_write(8'h78, 8'h21);
    io_write(8'h79, 8'h05);
    io_write(8'h7A, 8'h3F);
    io_write(8'h7B, 8'hC7);   // R2: bits 7:6 dropped -> page 0x07
    io_write(8'h7C, 8'h01);   // R3
    probe("R6", 16'h1234, 1, 0, mk_phys(6'h21, 16'h1234), 0, 1);
    probe("R6", 16'h4ABC, 1, 0, mk_phys(6'h05, 16'h4ABC), 1, 0);
    probe("R6", 16'hBFFF, 1, 0, 20'hFFFFF, 0, 1);
    probe("R2", 16'hC000, 1, 0, mk_phys(6'h07, 16'hC000), 1, 0);
  endtask

  task automatic t_enable_toggle;
    io_write(8'h7C, 8'h00);
    probe("R3", 16'h4ABC, 1, 0, 20'h04ABC, 1, 0);
    io_write(8'h7C, 8'hFE);   // bit 0 clear: stays off
    probe("R3", 16'h4ABC, 1, 0, 20'h04ABC, 1, 0);
    io_write(8'h7C, 8'h01);
    probe("R9", 16'h4ABC, 1, 0, mk_phys(6'h05, 16'h4ABC), 1, 0);
  endtask

  task automatic t_alias;
    io_write(8'h71, 8'h2A);
    probe("R4", 16'h4000, 1, 0, mk_phys(6'h2A, 16'h4000), 0, 1);
    io_write(8'h74, 8'h00);
    probe("R4", 16'h4000, 1, 0, 20'h04000, 1, 0);
    io_write(8'h74, 8'h01);
    probe("R4", 16'h4000, 1, 0, mk_phys(6'h2A, 16'h4000), 0, 1);
  endtask

  task automatic t_ignored_ports;
    io_write(8'h75, 8'h00);
    io_write(8'h76, 8'h3E);
    io_write(8'h77, 8'h3E);
    io_write(8'h7D, 8'h3E);
    io_write(8'h7F, 8'h00);
    io_write(8'h68, 8'h3E);
    io_write(8'hF8, 8'h00);
    io_write(8'h38, 8'h3E);
    probe("R5", 16'h0100, 1, 0, mk_phys(6'h21, 16'h0100), 0, 1);
    probe("R5", 16'h4100, 1, 0, mk_phys(6'h2A, 16'h4100), 0, 1);
    probe("R5", 16'h8100, 1, 0, mk_phys(6'h3F, 16'h8100), 0, 1);
    probe("R5", 16'hC100, 1, 0, mk_phys(6'h07, 16'hC100), 1, 0);
  endtask

  task automatic t_no_strobe;
    @(negedge clk);
    io_addr = 8'h78; io_wdata = 8'h10; io_wr = 1'b0;
    repeat (2) @(negedge clk);
    io_addr = 8'h7C; io_wdata = 8'h00;
    repeat (2) @(negedge clk);
    probe("R10", 16'h0200, 1, 0, mk_phys(6'h21, 16'h0200), 0, 1);
  endtask

  task automatic t_chip_select;
    probe("R7", 16'h4000, 0, 0, mk_phys(6'h2A, 16'h4000), 0, 0);
    probe("R7", 16'hC000, 0, 0, mk_phys(6'h07, 16'hC000), 0, 0);
    probe("R7", 16'h4000, 0, 1, mk_phys(6'h2A, 16'h4000), 0, 1);
    probe("R7", 16'hC000, 0, 1, mk_phys(6'h07, 16'hC000), 1, 0);
    probe("R7", 16'hC000, 1, 1, mk_phys(6'h07, 16'hC000), 1, 0);
  endtask

  task automatic t_shared_page;
    for (int w = 0; w < 4; w++) io_write(8'h78 + 8'(w), 8'h30);
    for (int w = 0; w < 4; w++)
      probe("R8", 16'(w << 14) | 16'h0010, 1, 0, 20'hC0010, 0, 1);
  endtask

  task automatic t_preload;
    io_write(8'h7C, 8'h00);
    io_write(8'h7B, 8'h1F);
    probe("R9", 16'hC000, 1, 0, 20'h0C000, 1, 0);
    io_write(8'h7C, 8'h01);
    probe("R9", 16'hC000, 1, 0, 20'h7C000, 1, 0);
    probe("R9", 16'h8000, 1, 0, 20'hC0000, 0, 1);
  endtask

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_wr = 1'b0;
    cpu_addr = '0; mem_rd = 1'b0; mem_wr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map_windows();
    t_enable_toggle();
    t_alias();
    t_ignored_ports();
    t_no_strobe();
    t_chip_select();
    t_shared_page();
    t_preload();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule